// File: doc/BRIEF.md
# Dual-Window Byte Register Space with Bit Operations

This block holds the 64 byte-wide control and status registers of a small 8-bit controller. The core reaches them through two address windows. The port window takes a 6-bit register number, 0x00 to 0x3F. The data-space window takes a memory address in which the same registers sit 0x20 higher, at 0x20 to 0x5F. Each request asks for one of these: a byte read, a byte write, a single-bit set, a single-bit clear, or a single-bit test. The bit operations are accepted only on the lower 32 registers. Set and clear work as a read-modify-write of the whole byte.

One register is a sample status register. Its low nibble holds flags that hardware sets and that software clears by writing ones. Its high nibble holds plain control bits. Because set and clear write back the whole byte, any flag that reads as one is cleared by a set or clear aimed at another bit of that register. A few register numbers are reserved. They read as zero and ignore every write.

Reads are combinational and answer in the same cycle. A write, set or clear takes effect at the next rising clock edge. A bit-test result and the error strobe for a rejected bit operation are valid in the request cycle only.

Top module: `ioreg_space`

## Requirements
- R1: In the port window (`req_win`=0), addresses 0x00–0x3F select register number = address. Any address of 0x40 or above is not selected: `rsp_rdata` is 0 and no state changes.
- R2: In the data window (`req_win`=1), addresses 0x20–0x5F select register number = address − 0x20. Addresses outside that range are not selected: `rsp_rdata` is 0 and no state changes.
- R3: Op codes are 0 = read, 1 = byte write, 2 = bit set, 3 = bit clear, 4 = bit test. Codes 5–7 change nothing. `rsp_rdata` shows the selected register in the same cycle. A byte write is visible from the next clock edge. When no request is valid, `rsp_rdata` is 0.
- R4: A bit set (2) or bit clear (3) on register numbers 0x00–0x1F changes only bit `req_bit` (0 = LSB). The result is written back as a full byte at the next edge.
- R5: Any bit operation (codes 2, 3 or 4) on register numbers 0x20–0x3F pulses `rsp_err` in the request cycle and changes no register.
- R6: A bit test (4) on register numbers 0x00–0x1F raises `rsp_tvalid` in the request cycle, with `rsp_tflag` equal to bit `req_bit` of the register. `rsp_tvalid` and `rsp_tflag` are 0 in every other case.
- R7: The status register is number 0x0A. Its bits [3:0] are flags: writing a 1 to a flag clears it, and writing a 0 leaves it unchanged. Its bits [7:4] are ordinary read/write control bits.
- R8: A bit set or bit clear on the status register writes back the modified byte. Every flag that is 1 in that byte is cleared. So a clear aimed at a set flag leaves that flag set, and a set aimed at any bit clears all other flags that were set.
- R9: A 1 on `hw_flag_set[i]` (i = 0–3) sets status flag i at the next edge. In the same cycle it takes priority over a software clear of that flag. Bits [7:4] of `hw_flag_set` have no effect.
- R10: Register numbers 0x00, 0x01 and 0x3F are reserved. They read as 0, and writes of any kind to them change nothing. A bit operation on them pulses `rsp_err`.
- R11: While `rst_n` is low at a rising edge, every register and flag is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_win | input | 1 | 0 = port window, 1 = data window |
| req_addr | input | 16 | Address within the chosen window |
| req_op | input | 3 | Operation code |
| req_bit | input | 3 | Bit index for set, clear and test |
| req_wdata | input | 8 | Byte write data |
| hw_flag_set | input | 8 | Hardware set strobes for the status flags |
| rsp_rdata | output | 8 | Selected register value, or 0 |
| rsp_err | output | 1 | Rejected bit operation strobe |
| rsp_tvalid | output | 1 | Bit-test result valid |
| rsp_tflag | output | 1 | Bit-test result |

## Verification
Read data, the error strobe and the bit-test flag are all due in the same cycle as the request. The bench drives each request at a falling edge and samples these outputs 2 ns later, before the next rising edge. The effect of a write, set, clear or hardware flag set is due one edge later. The bench's reference model applies it only after that rising edge, so the next request in either window must show the new value. A reset is checked by reading registers back after reset is released.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_BSET  = 3'd2,
    OP_BCLR  = 3'd3,
    OP_BTEST = 3'd4
  } io_op_e;

  // Translate a window address to a register number.
  function automatic logic [31:0] win_to_index(input logic win,
                                               input logic [31:0] a,
                                               input logic [31:0] base);
    return win ? (a - base) : a;
  endfunction

  // Single-bit modification of a byte.
  function automatic logic [BYTE_W-1:0] bit_apply(input logic [BYTE_W-1:0] v,
                                                  input logic [2:0] b,
                                                  input logic set);
    logic [BYTE_W-1:0] m;
    m = BYTE_W'(1) << b;
    return set ? (v | m) : (v & ~m);
  endfunction

  // Write-one-to-clear flag update; hardware set applied last so it wins.
  function automatic logic [BYTE_W-1:0] flag_next(input logic [BYTE_W-1:0] cur,
                                                  input logic [BYTE_W-1:0] wval,
                                                  input logic [BYTE_W-1:0] hw,
                                                  input logic [BYTE_W-1:0] mask);
    return ((cur & ~wval) | hw) & mask;
  endfunction

endpackage

// File: rtl/ioreg_decode.sv
module ioreg_decode
  import ioreg_pkg::*;
#(
  parameter int AW      = 16,
  parameter int NREG    = 64,
  parameter int IW      = 6,
  parameter int BITLIM  = 32,
  parameter int DS_BASE = 32,
  parameter logic [NREG-1:0] RSV_MAP = '0
) (
  input  logic          valid,
  input  logic          win,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    op,
  output logic          hit,
  output logic          rsv,
  output logic [IW-1:0] idx,
  output logic          acc_ok,
  output logic          bit_exec,
  output logic          bit_err,
  output logic          is_wr
);

  logic [31:0] a32;
  logic [31:0] ix32;
  logic        is_bitop;
  logic        is_setclr;
  logic        low_half;

  always_comb begin
    a32  = 32'(addr);
    ix32 = win_to_index(win, a32, 32'(DS_BASE));
    if (win)
      hit = (a32 >= 32'(DS_BASE)) && (a32 < 32'(DS_BASE + NREG));
    else
      hit = (a32 < 32'(NREG));
  end

  assign idx       = ix32[IW-1:0];
  assign rsv       = RSV_MAP[idx];
  assign low_half  = (ix32 < 32'(BITLIM));
  assign is_setclr = (op == OP_BSET) || (op == OP_BCLR);
  assign is_bitop  = is_setclr || (op == OP_BTEST);

  assign acc_ok   = valid && hit && !rsv;
  assign bit_exec = acc_ok && is_bitop && low_half;
  assign bit_err  = valid && hit && is_bitop && (!low_half || rsv);
  assign is_wr    = acc_ok && ((op == OP_WRITE) || (is_setclr && low_half));

endmodule

// File: rtl/ioreg_file.sv
module ioreg_file
  import ioreg_pkg::*;
#(
  parameter int NREG = 64,
  parameter int IW   = 6,
  parameter int SKIP = 10,
  parameter logic [NREG-1:0] RSV_MAP = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IW-1:0]          widx,
  input  logic [BYTE_W-1:0]      wdata,
  output logic [NREG*BYTE_W-1:0] q_flat
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == SKIP || RSV_MAP[i]) begin : g_none
      assign q_flat[i*BYTE_W +: BYTE_W] = '0;
    end else begin : g_ff
      logic [BYTE_W-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n)
          r <= '0;
        else if (we && (widx == IW'(i)))
          r <= wdata;
      end
      assign q_flat[i*BYTE_W +: BYTE_W] = r;
    end
  end

endmodule

// File: rtl/ioreg_status.sv
module ioreg_status
  import ioreg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FLAG_MASK = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] hw_set,
  output logic [BYTE_W-1:0] q
);

  logic [BYTE_W-1:0] wval;
  logic [BYTE_W-1:0] ctrl_nxt;
  logic [BYTE_W-1:0] flag_nxt;

  assign wval     = we ? wdata : '0;
  assign ctrl_nxt = (we ? wdata : q) & ~FLAG_MASK;
  assign flag_nxt = flag_next(q, wval, hw_set, FLAG_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= '0;
    else
      q <= ctrl_nxt | flag_nxt;
  end

endmodule

// File: rtl/ioreg_space.sv
module ioreg_space
  import ioreg_pkg::*;
#(
  parameter int AW        = 16,
  parameter int NREG      = 64,
  parameter int BITLIM    = 32,
  parameter int DS_BASE   = 32,
  parameter int STAT_ADDR = 10,
  parameter logic [7:0] FLAG_MASK = 8'h0F,
  parameter logic [NREG-1:0] RSV_MAP = 64'h8000_0000_0000_0003
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_win,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_op,
  input  logic [2:0]    req_bit,
  input  logic [7:0]    req_wdata,
  input  logic [7:0]    hw_flag_set,
  output logic [7:0]    rsp_rdata,
  output logic          rsp_err,
  output logic          rsp_tvalid,
  output logic          rsp_tflag
);

  localparam int IW = $clog2(NREG);

  logic                   dec_hit;
  logic                   dec_rsv;
  logic [IW-1:0]          dec_idx;
  logic                   acc_ok;
  logic                   bit_exec;
  logic                   bit_err;
  logic                   wr_fire;
  logic                   at_stat;
  logic [7:0]             cur_val;
  logic [7:0]             next_val;
  logic [7:0]             stat_q;
  logic [NREG*BYTE_W-1:0] file_flat;

  ioreg_decode #(
    .AW(AW), .NREG(NREG), .IW(IW), .BITLIM(BITLIM),
    .DS_BASE(DS_BASE), .RSV_MAP(RSV_MAP)
  ) u_dec (
    .valid   (req_valid),
    .win     (req_win),
    .addr    (req_addr),
    .op      (req_op),
    .hit     (dec_hit),
    .rsv     (dec_rsv),
    .idx     (dec_idx),
    .acc_ok  (acc_ok),
    .bit_exec(bit_exec),
    .bit_err (bit_err),
    .is_wr   (wr_fire)
  );

  assign at_stat  = (dec_idx == IW'(STAT_ADDR));
  assign cur_val  = at_stat ? stat_q : file_flat[{dec_idx, 3'b000} +: BYTE_W];
  assign next_val = (req_op == OP_WRITE) ? req_wdata
                                         : bit_apply(cur_val, req_bit, req_op == OP_BSET);

  ioreg_file #(
    .NREG(NREG), .IW(IW), .SKIP(STAT_ADDR), .RSV_MAP(RSV_MAP)
  ) u_file (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fire && !at_stat),
    .widx  (dec_idx),
    .wdata (next_val),
    .q_flat(file_flat)
  );

  ioreg_status #(
    .FLAG_MASK(FLAG_MASK)
  ) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fire && at_stat),
    .wdata (next_val),
    .hw_set(hw_flag_set & FLAG_MASK),
    .q     (stat_q)
  );

  assign rsp_rdata  = acc_ok ? cur_val : '0;
  assign rsp_err    = bit_err;
  assign rsp_tvalid = bit_exec && (req_op == OP_BTEST);
  assign rsp_tflag  = rsp_tvalid && cur_val[req_bit];

endmodule

// File: rtl/ioreg_chk.sv
module ioreg_chk #(
  parameter int NREG = 64,
  parameter logic [7:0] FLAG_MASK = 8'h0F
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid,
  input logic            hit,
  input logic            rsv,
  input logic            bit_err,
  input logic            tvalid,
  input logic [7:0]      rdata,
  input logic [7:0]      stat_q,
  input logic [7:0]      hw_set,
  input logic [NREG*8-1:0] file_flat
);

  // R1
  unsel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit) |-> (rdata == 8'h00));

  // R5
  err_nochange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_err && ((hw_set & FLAG_MASK) == 8'h00)) |=> ($stable(file_flat) && $stable(stat_q)));

  // R6
  err_notest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> !tvalid);

  // R9
  hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_set & FLAG_MASK) != 8'h00) |=>
      ((stat_q & $past(hw_set & FLAG_MASK)) == $past(hw_set & FLAG_MASK)));

  // R10
  rsv_nochange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && hit && rsv && ((hw_set & FLAG_MASK) == 8'h00)) |=>
      ($stable(file_flat) && $stable(stat_q)));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    (!rst_n) |=> ((file_flat == '0) && (stat_q == 8'h00)));

endmodule

bind ioreg_space ioreg_chk #(
  .NREG(NREG), .FLAG_MASK(FLAG_MASK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid    (req_valid),
  .hit      (dec_hit),
  .rsv      (dec_rsv),
  .bit_err  (bit_err),
  .tvalid   (rsp_tvalid),
  .rdata    (rsp_rdata),
  .stat_q   (stat_q),
  .hw_set   (hw_flag_set),
  .file_flat(file_flat)
);

// File: tb/sim_ioreg_space.sv
module sim_ioreg_space;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_win = 1'b0;
  logic [15:0] req_addr = '0;
  logic [2:0]  req_op = '0;
  logic [2:0]  req_bit = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  hw_flag_set = '0;
  logic [7:0]  rsp_rdata;
  logic        rsp_err;
  logic        rsp_tvalid;
  logic        rsp_tflag;

  always #5 clk = ~clk;

  ioreg_space u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_win(req_win),
    .req_addr(req_addr), .req_op(req_op), .req_bit(req_bit),
    .req_wdata(req_wdata), .hw_flag_set(hw_flag_set), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .rsp_tvalid(rsp_tvalid), .rsp_tflag(rsp_tflag)
  );

  int total = 0;
  int bad = 0;
  int mdl [64];

  function automatic bit is_rsv(int i);
    return (i == 0) || (i == 1) || (i == 63);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 64; i++) mdl[i] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; hw_flag_set = '0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    clear_model();
  endtask

  // One request cycle: compare same-cycle outputs, then apply effect after the edge.
  task automatic op(int k, bit w, int a, int b, int wd, int hw, string tag);
    bit hit; bit rs; bit bop; bit tv; bit wr;
    int idx; int cur; int wv;
    @(negedge clk);
    req_valid = 1'b1; req_win = w; req_addr = 16'(a); req_op = 3'(k);
    req_bit = 3'(b); req_wdata = 8'(wd); hw_flag_set = 8'(hw);
    if (w) begin hit = (a >= 32) && (a < 96); idx = a - 32; end
    else   begin hit = (a < 64);              idx = a;      end
    rs  = hit && is_rsv(idx);
    cur = (hit && !rs) ? mdl[idx] : 0;
    bop = (k >= 2) && (k <= 4);
    tv  = hit && !rs && (idx < 32) && (k == 4);
    #2;
    check(tag, "rdata", int'(rsp_rdata), cur);
    check(tag, "err", int'(rsp_err), int'(hit && bop && ((idx >= 32) || rs)));
    check(tag, "tvalid", int'(rsp_tvalid), int'(tv));
    check(tag, "tflag", int'(rsp_tflag), tv ? ((cur >> b) & 1) : 0);
    wr = 1'b0; wv = 0;
    if (hit && !rs) begin
      if (k == 1) begin wr = 1'b1; wv = wd & 255; end
      else if ((k == 2 || k == 3) && idx < 32) begin
        wr = 1'b1;
        wv = (k == 2) ? (cur | (1 << b)) : (cur & ~(1 << b) & 255);
      end
    end
    @(posedge clk);
    if (wr) begin
      if (idx == 10) mdl[10] = (wv & 8'hF0) | (cur & 8'h0F & ~wv);
      else           mdl[idx] = wv;
    end
    mdl[10] = mdl[10] | (hw & 8'h0F);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    req_valid = 1'b0; hw_flag_set = '0; req_op = 3'd0;
    #2;
    check(tag, "idle rdata", int'(rsp_rdata), 0);
    check(tag, "idle tvalid", int'(rsp_tvalid), 0);
  endtask

  function automatic string tag_of(int k);
    if (k == 2 || k == 3) return "R4";
    if (k == 4) return "R6";
    return "R3";
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    clear_model();
    do_reset();
    // R11: reset state
    op(0, 0, 5, 0, 0, 0, "R11");
    op(0, 0, 10, 0, 0, 0, "R11");
    // R3 write then read, R2 alias
    op(1, 0, 5, 0, 8'hA5, 0, "R3");
    op(0, 0, 5, 0, 0, 0, "R3");
    op(0, 1, 8'h25, 0, 0, 0, "R2");
    op(1, 1, 8'h5E, 0, 8'h3C, 0, "R2");
    op(0, 0, 8'h3E, 0, 0, 0, "R2");
    op(0, 1, 8'h1F, 0, 0, 0, "R2");
    op(1, 1, 8'h60, 0, 8'hFF, 0, "R2");
    op(0, 1, 8'h60, 0, 0, 0, "R2");
    op(1, 0, 8'h40, 0, 8'h77, 0, "R1");
    op(0, 0, 8'h40, 0, 0, 0, "R1");
    op(0, 0, 0, 0, 0, 0, "R1");
    // R10 reserved
    op(1, 1, 8'h5F, 0, 8'h99, 0, "R10");
    op(0, 0, 8'h3F, 0, 0, 0, "R10");
    op(2, 0, 1, 3, 0, 0, "R10");
    op(0, 0, 1, 0, 0, 0, "R10");
    // R4 bit set / clear
    op(2, 0, 5, 1, 0, 0, "R4");
    op(3, 1, 8'h25, 0, 0, 0, "R4");
    op(2, 0, 8'h1F, 7, 0, 0, "R4");
    op(0, 0, 8'h1F, 0, 0, 0, "R4");
    // R5 rejected upper half
    op(1, 0, 8'h30, 0, 8'h81, 0, "R5");
    op(2, 0, 8'h30, 2, 0, 0, "R5");
    op(3, 1, 8'h50, 0, 0, 0, "R5");
    op(4, 0, 8'h30, 0, 0, 0, "R5");
    op(0, 0, 8'h30, 0, 0, 0, "R5");
    // R6 bit test
    for (int b = 0; b < 8; b++) op(4, 0, 5, b, 0, 0, "R6");
    op(4, 1, 8'h3F, 7, 0, 0, "R6");
    // R7 status flags and control
    op(0, 0, 10, 0, 0, 8'hFF, "R9");
    op(0, 0, 10, 0, 0, 0, "R9");
    op(1, 0, 10, 0, 8'h03, 0, "R7");
    op(0, 0, 10, 0, 0, 0, "R7");
    op(1, 1, 8'h2A, 0, 8'h50, 0, "R7");
    op(0, 0, 10, 0, 0, 0, "R7");
    // R8 read-modify-write side effect
    op(2, 0, 10, 6, 0, 0, "R8");
    op(0, 0, 10, 0, 0, 0, "R8");
    op(0, 0, 10, 0, 0, 8'h0F, "R8");
    op(3, 0, 10, 2, 0, 0, "R8");
    op(0, 0, 10, 0, 0, 0, "R8");
    op(2, 0, 10, 2, 0, 0, "R8");
    op(0, 0, 10, 0, 0, 0, "R8");
    // R9 hardware set beats clear
    op(0, 0, 10, 0, 0, 8'h0F, "R9");
    op(1, 0, 10, 0, 8'h0F, 8'h04, "R9");
    op(0, 0, 10, 0, 0, 0, "R9");
    // R3 undefined op codes
    op(5, 0, 5, 0, 8'h11, 0, "R3");
    op(7, 0, 5, 0, 8'h11, 0, "R3");
    op(0, 0, 5, 0, 0, 0, "R3");
    idle("R3");
    // mixed traffic
    seed = 32'd12345;
    for (int n = 0; n < 300; n++) begin
      int k; bit w; int a;
      seed = seed * 32'd1103515245 + 32'd12345;
      k = int'((seed >> 8) % 6);
      w = seed[20];
      a = w ? int'((seed >> 21) % 104) : int'((seed >> 21) % 72);
      op(k, w, a, int'((seed >> 4) & 7), int'((seed >> 12) & 255),
         (seed[3:0] == 4'h0) ? int'((seed >> 24) & 15) : 0, tag_of(k));
      if (seed[27:25] == 3'd0) idle("R3");
    end
    for (int i = 0; i < 64; i++) op(0, 0, i, 0, 0, 0, "R1");
    for (int i = 32; i < 96; i++) op(0, 1, i, 0, 0, 0, "R2");
    // R11 reset after traffic
    do_reset();
    for (int i = 0; i < 64; i++) op(0, 0, i, 0, 0, 0, "R11");
    idle("R11");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule